// File: doc/BRIEF.md
# Cascaded Tick and Interval Timer with Free-Running Counter

This block is a per-core local timer. A tick stage counts down on every cycle where the tick-enable input is high. Each time the tick stage expires, it advances a second interval stage by one. When the interval stage runs out, it raises an interrupt. In auto-reload mode both stages then start a new period. In one-shot mode the interval stage stops itself. Next to this pair sits an independent free-running down-counter with its own reload buffer and its own interrupt source. Both sources share one level interrupt output.

Software reaches the block through a simple synchronous 32-bit register bus:
- Writes are single-cycle strobes.
- Reads are combinational from the address.

Each reload value goes to a buffer register. The live counts can be read back through read-only observation registers. The interval buffer has a manual-update bit that loads the interval stage at once. Per-register write-acknowledge bits record which registers have been written.

Top module: `core_tick_timer`

## Requirements
- R1: After reset (`rst_ni` low) every register and counter reads zero, all stages are stopped and `irq_o` is low.
- R2: Control bits:
  - bit 0 runs the tick stage;
  - bit 1 runs the interval stage;
  - bit 2 selects auto-reload (interval) mode;
  - bit 3 runs the free-running counter.
  
  A counter changes only on a rising clock edge with `tick_i` high and its run bit set. While stopped it holds its count, which stays readable, and on restart it resumes from that count.
- R3: A tick with the tick count at 0 is a tick expiry: the tick stage reloads from its buffer. A buffer value N therefore gives a period of N+1 ticks. A new buffer value reaches the counter only at the next expiry.
- R4: On each tick expiry with control bit 1 set, the interval stage decrements by one. If the interval count is already 0 at that expiry, the interval stage expires:
  - status bit 0 is set;
  - in auto-reload mode the interval stage reloads from its buffer;
  - otherwise it stays at 0 and control bit 1 clears itself.
  
  With buffers N and M, a freshly loaded pair expires after (M+1)*(N+1) ticks.
- R5: A write to the interval buffer with bit 31 set loads bits 30:0 into the interval count in the same cycle. Bit 31 is not stored, and the buffer reads back bits 30:0 only.
- R6: Free-running counter:
  - A write to its buffer also loads its count.
  - A tick with count 1 sets status bit 1 and reloads the count from the buffer.
  - A tick at any other count decrements it, wrapping from 0 to 0xFFFFFFFF, so a buffer value of 0 gives a period of 2^32 ticks.
- R7: Write-acknowledge bits are set by writes to these registers and cleared by writing 1 to them:

  | Bit | Set by a write to |
  |-----|-------------------|
  | 0 | tick buffer |
  | 1 | interval buffer |
  | 2 | free-running buffer |
  | 3 | control register |
- R8: Interrupt status bits are cleared by writing 1 to them. A new event wins over a clear in the same cycle. `irq_o` is high exactly when some status bit and its matching enable bit (bit 0 interval, bit 1 free-running) are both set. Enabling a source whose status is pending raises `irq_o` at once.
- R9: Writes to the three observation registers (tick count, interval count, free count) have no effect.
- R10: Register byte offsets:

  | Offset | Register |
  |--------|----------|
  | 0x00 | control |
  | 0x04 | tick buffer |
  | 0x08 | tick count |
  | 0x0C | interval buffer |
  | 0x10 | interval count |
  | 0x14 | free-running buffer |
  | 0x18 | free count |
  | 0x1C | interrupt status |
  | 0x20 | interrupt enable |
  | 0x24 | write-acknowledge |

  Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable; each high cycle is one tick |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The hardest case to reach is an interval expiry at an exact tick count. It needs the interval count at zero and the tick count at zero on the same tick, and the outcome differs between one-shot and auto-reload mode. The stimulus uses the manual-update bit to place a known interval count. It then issues counted single tick pulses, so the expiry cycle is known in advance. Status, control and counts are read back just before and just after that tick. The 2^32 period of a zero free-running buffer is covered by checking the wrap from 0 to 0xFFFFFFFF with no status set.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADR_CTRL     = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_TICK_BUF = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_TICK_CUR = 6'h08;
  localparam logic [ADDR_W-1:0] ADR_IVL_BUF  = 6'h0C;
  localparam logic [ADDR_W-1:0] ADR_IVL_CUR  = 6'h10;
  localparam logic [ADDR_W-1:0] ADR_FREE_BUF = 6'h14;
  localparam logic [ADDR_W-1:0] ADR_FREE_CUR = 6'h18;
  localparam logic [ADDR_W-1:0] ADR_INT_STAT = 6'h1C;
  localparam logic [ADDR_W-1:0] ADR_INT_EN   = 6'h20;
  localparam logic [ADDR_W-1:0] ADR_WR_STAT  = 6'h24;

  localparam int unsigned N_SRC = 2;  // 0: interval stage, 1: free-running

  typedef struct packed {
    logic free_run;
    logic interval;
    logic ivl_run;
    logic tick_run;
  } ctrl_t;
endpackage

// File: rtl/ctt_cascade.sv
module ctt_cascade #(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned IVL_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tick_run_i,
  input  logic              ivl_run_i,
  input  logic              interval_i,
  input  logic [TICK_W-1:0] tick_buf_i,
  input  logic [IVL_W-1:0]  ivl_buf_i,
  input  logic              ivl_load_i,
  input  logic [IVL_W-1:0]  ivl_load_val_i,
  output logic [TICK_W-1:0] tick_cnt_o,
  output logic [IVL_W-1:0]  ivl_cnt_o,
  output logic              ivl_done_o
);
  logic [TICK_W-1:0] tick_q;
  logic [IVL_W-1:0]  ivl_q;
  logic              tick_exp, ivl_step;

  assign tick_exp   = tick_i & tick_run_i & (tick_q == '0);
  assign ivl_step   = tick_exp & ivl_run_i;
  assign ivl_done_o = ivl_step & (ivl_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
    end else if (tick_i && tick_run_i) begin
      tick_q <= tick_exp ? tick_buf_i : tick_q - 1'b1;
    end
  end

  // manual load beats a same-cycle step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= '0;
    end else if (ivl_load_i) begin
      ivl_q <= ivl_load_val_i;
    end else if (ivl_done_o) begin
      if (interval_i) ivl_q <= ivl_buf_i;
    end else if (ivl_step) begin
      ivl_q <= ivl_q - 1'b1;
    end
  end

  assign tick_cnt_o = tick_q;
  assign ivl_cnt_o  = ivl_q;
endmodule

// File: rtl/ctt_free.sv
module ctt_free #(
  parameter int unsigned FREE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [FREE_W-1:0] buf_i,
  input  logic              load_i,
  input  logic [FREE_W-1:0] load_val_i,
  output logic [FREE_W-1:0] cnt_o,
  output logic              done_o
);
  localparam logic [FREE_W-1:0] ONE = FREE_W'(1);

  logic [FREE_W-1:0] cnt_q;

  assign done_o = tick_i & run_i & (cnt_q == ONE);

  // buffer 0 reloads 0, which wraps: 2^FREE_W ticks per period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && run_i) begin
      cnt_q <= done_o ? buf_i : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ctt_regs.sv
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned IVL_W  = 31,
  parameter int unsigned FREE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [TICK_W-1:0]  tick_cnt_i,
  input  logic [IVL_W-1:0]   ivl_cnt_i,
  input  logic [FREE_W-1:0]  free_cnt_i,
  input  logic               ivl_done_i,
  input  logic               free_done_i,
  output ctrl_t              ctrl_o,
  output logic [TICK_W-1:0]  tick_buf_o,
  output logic [IVL_W-1:0]   ivl_buf_o,
  output logic [FREE_W-1:0]  free_buf_o,
  output logic               ivl_load_o,
  output logic               free_load_o,
  output logic [N_SRC-1:0]   stat_o,
  output logic [N_SRC-1:0]   en_o,
  output logic [3:0]         wstat_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int unsigned MAN_BIT = DATA_W - 1;

  ctrl_t              ctrl_q;
  logic [TICK_W-1:0]  tick_buf_q;
  logic [IVL_W-1:0]   ivl_buf_q;
  logic [FREE_W-1:0]  free_buf_q;
  logic [N_SRC-1:0]   stat_q, en_q, stat_clr, stat_set;
  logic [3:0]         wstat_q, wstat_set, wstat_clr;
  logic wr_ctrl, wr_tick, wr_ivl, wr_free, wr_stat, wr_en, wr_wstat;

  assign wr_ctrl  = we_i && (addr_i == ADR_CTRL);
  assign wr_tick  = we_i && (addr_i == ADR_TICK_BUF);
  assign wr_ivl   = we_i && (addr_i == ADR_IVL_BUF);
  assign wr_free  = we_i && (addr_i == ADR_FREE_BUF);
  assign wr_stat  = we_i && (addr_i == ADR_INT_STAT);
  assign wr_en    = we_i && (addr_i == ADR_INT_EN);
  assign wr_wstat = we_i && (addr_i == ADR_WR_STAT);

  assign stat_set  = {free_done_i, ivl_done_i};
  assign stat_clr  = wr_stat ? wdata_i[N_SRC-1:0] : '0;
  assign wstat_set = {wr_ctrl, wr_free, wr_ivl, wr_tick};
  assign wstat_clr = wr_wstat ? wdata_i[3:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      tick_buf_q <= '0;
      ivl_buf_q  <= '0;
      free_buf_q <= '0;
      en_q       <= '0;
      stat_q     <= '0;
      wstat_q    <= '0;
    end else begin
      if (wr_ctrl)                             ctrl_q <= ctrl_t'(wdata_i[3:0]);
      else if (ivl_done_i && !ctrl_q.interval) ctrl_q.ivl_run <= 1'b0;
      if (wr_tick) tick_buf_q <= wdata_i[TICK_W-1:0];
      if (wr_ivl)  ivl_buf_q  <= wdata_i[IVL_W-1:0];
      if (wr_free) free_buf_q <= wdata_i[FREE_W-1:0];
      if (wr_en)   en_q       <= wdata_i[N_SRC-1:0];
      stat_q  <= (stat_q & ~stat_clr) | stat_set;
      wstat_q <= (wstat_q & ~wstat_clr) | wstat_set;
    end
  end

  always_comb begin
    irq_o = 1'b0;
    for (int i = 0; i < N_SRC; i++) irq_o = irq_o | (stat_q[i] & en_q[i]);
  end

  always_comb begin
    unique case (addr_i)
      ADR_CTRL:     rdata_o = DATA_W'(ctrl_q);
      ADR_TICK_BUF: rdata_o = DATA_W'(tick_buf_q);
      ADR_TICK_CUR: rdata_o = DATA_W'(tick_cnt_i);
      ADR_IVL_BUF:  rdata_o = DATA_W'(ivl_buf_q);
      ADR_IVL_CUR:  rdata_o = DATA_W'(ivl_cnt_i);
      ADR_FREE_BUF: rdata_o = DATA_W'(free_buf_q);
      ADR_FREE_CUR: rdata_o = DATA_W'(free_cnt_i);
      ADR_INT_STAT: rdata_o = DATA_W'(stat_q);
      ADR_INT_EN:   rdata_o = DATA_W'(en_q);
      ADR_WR_STAT:  rdata_o = DATA_W'(wstat_q);
      default:      rdata_o = '0;
    endcase
  end

  assign ivl_load_o  = wr_ivl && wdata_i[MAN_BIT];
  assign free_load_o = wr_free;
  assign ctrl_o      = ctrl_q;
  assign tick_buf_o  = tick_buf_q;
  assign ivl_buf_o   = ivl_buf_q;
  assign free_buf_o  = free_buf_q;
  assign stat_o      = stat_q;
  assign en_o        = en_q;
  assign wstat_o     = wstat_q;
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import ctt_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned IVL_W  = 31,
  parameter int unsigned FREE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [TICK_W-1:0] tick_buf, tick_cnt;
  logic [IVL_W-1:0]  ivl_buf, ivl_cnt;
  logic [FREE_W-1:0] free_buf, free_cnt;
  logic              ivl_load, free_load, ivl_done, free_done;
  logic [N_SRC-1:0]  stat, en;
  logic [3:0]        wstat;

  ctt_regs #(.TICK_W(TICK_W), .IVL_W(IVL_W), .FREE_W(FREE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .tick_cnt_i  (tick_cnt),
    .ivl_cnt_i   (ivl_cnt),
    .free_cnt_i  (free_cnt),
    .ivl_done_i  (ivl_done),
    .free_done_i (free_done),
    .ctrl_o      (ctrl),
    .tick_buf_o  (tick_buf),
    .ivl_buf_o   (ivl_buf),
    .free_buf_o  (free_buf),
    .ivl_load_o  (ivl_load),
    .free_load_o (free_load),
    .stat_o      (stat),
    .en_o        (en),
    .wstat_o     (wstat),
    .rdata_o     (rdata_o),
    .irq_o       (irq_o)
  );

  ctt_cascade #(.TICK_W(TICK_W), .IVL_W(IVL_W)) u_cascade (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .tick_run_i     (ctrl.tick_run),
    .ivl_run_i      (ctrl.ivl_run),
    .interval_i     (ctrl.interval),
    .tick_buf_i     (tick_buf),
    .ivl_buf_i      (ivl_buf),
    .ivl_load_i     (ivl_load),
    .ivl_load_val_i (wdata_i[IVL_W-1:0]),
    .tick_cnt_o     (tick_cnt),
    .ivl_cnt_o      (ivl_cnt),
    .ivl_done_o     (ivl_done)
  );

  ctt_free #(.FREE_W(FREE_W)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (ctrl.free_run),
    .buf_i      (free_buf),
    .load_i     (free_load),
    .load_val_i (wdata_i[FREE_W-1:0]),
    .cnt_o      (free_cnt),
    .done_o     (free_done)
  );
endmodule

// File: rtl/ctt_checker.sv
module ctt_checker
  import ctt_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned IVL_W  = 31,
  parameter int unsigned FREE_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [3:0]        ctrl,
  input logic [TICK_W-1:0] tick_buf,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [IVL_W-1:0]  ivl_cnt,
  input logic [FREE_W-1:0] free_buf,
  input logic [FREE_W-1:0] free_cnt,
  input logic [N_SRC-1:0]  stat,
  input logic [3:0]        wstat
);
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[0] |=> $stable(tick_cnt)); // R2

  AST_TICK_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[0] && tick_i && tick_cnt == '0) |=> tick_cnt == $past(tick_buf)); // R3

  AST_IVL_MANUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_IVL_BUF && wdata_i[DATA_W-1])
      |=> ivl_cnt == $past(wdata_i[IVL_W-1:0])); // R5

  AST_FREE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[3] && tick_i && free_cnt == FREE_W'(1) && !(we_i && addr_i == ADR_FREE_BUF))
      |=> (stat[1] && free_cnt == $past(free_buf))); // R6

  AST_WSTAT_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_CTRL) |=> wstat[3]); // R7

  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[0] && !(we_i && addr_i == ADR_INT_STAT)) |=> stat[0]); // R8
endmodule

bind core_tick_timer ctt_checker #(.TICK_W(TICK_W), .IVL_W(IVL_W), .FREE_W(FREE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .ctrl     (ctrl),
  .tick_buf (tick_buf),
  .tick_cnt (tick_cnt),
  .ivl_cnt  (ivl_cnt),
  .free_buf (free_buf),
  .free_cnt (free_cnt),
  .stat     (stat),
  .wstat    (wstat)
);

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb;
  import ctt_pkg::*;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] waddr;
    logic [31:0]       wdata;
    logic [3:0]        nt;
    logic [ADDR_W-1:0] raddr;
    logic [31:0]       exp;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_CTRL,     32'h0,        4'd1},  // R1
    '{1'b1, ADR_TICK_BUF, 32'd2,        4'd0, ADR_TICK_BUF, 32'd2,        4'd10}, // R10
    '{1'b1, ADR_IVL_BUF,  32'h8000_0001, 4'd0, ADR_IVL_CUR, 32'd1,        4'd5},  // R5
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_IVL_BUF,  32'd1,        4'd5},  // R5
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_WR_STAT,  32'h3,        4'd7},  // R7
    '{1'b1, ADR_WR_STAT,  32'hF,        4'd0, ADR_WR_STAT,  32'h0,        4'd7},  // R7
    '{1'b1, ADR_INT_EN,   32'h1,        4'd0, ADR_INT_EN,   32'h1,        4'd10}, // R10
    '{1'b1, ADR_CTRL,     32'h3,        4'd1, ADR_TICK_CUR, 32'd2,        4'd3},  // R3
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_IVL_CUR,  32'd0,        4'd4},  // R4
    '{1'b0, ADR_CTRL,     32'h0,        4'd2, ADR_INT_STAT, 32'h0,        4'd4},  // R4
    '{1'b0, ADR_CTRL,     32'h0,        4'd1, ADR_INT_STAT, 32'h1,        4'd4},  // R4
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_CTRL,     32'h1,        4'd4},  // R4 one-shot
    '{1'b1, ADR_INT_STAT, 32'h1,        4'd0, ADR_INT_STAT, 32'h0,        4'd8},  // R8
    '{1'b1, ADR_TICK_CUR, 32'h55,       4'd0, ADR_TICK_CUR, 32'd2,        4'd9},  // R9
    '{1'b1, ADR_CTRL,     32'h7,        4'd3, ADR_INT_STAT, 32'h1,        4'd4},  // R4
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_IVL_CUR,  32'd1,        4'd4},  // R4 reload
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_CTRL,     32'h7,        4'd2},  // R2
    '{1'b1, ADR_TICK_BUF, 32'd0,        4'd2, ADR_TICK_CUR, 32'd0,        4'd3},  // R3 buffered
    '{1'b0, ADR_CTRL,     32'h0,        4'd1, ADR_IVL_CUR,  32'd0,        4'd4},  // R4
    '{1'b0, ADR_CTRL,     32'h0,        4'd1, ADR_IVL_CUR,  32'd1,        4'd4},  // R4
    '{1'b1, ADR_CTRL,     32'h0,        4'd5, ADR_IVL_CUR,  32'd1,        4'd2},  // R2 hold
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_TICK_CUR, 32'd0,        4'd2},  // R2
    '{1'b1, ADR_FREE_BUF, 32'd3,        4'd0, ADR_FREE_CUR, 32'd3,        4'd6},  // R6
    '{1'b1, ADR_CTRL,     32'h8,        4'd2, ADR_FREE_CUR, 32'd1,        4'd6},  // R6
    '{1'b0, ADR_CTRL,     32'h0,        4'd1, ADR_INT_STAT, 32'h3,        4'd6},  // R6
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_FREE_CUR, 32'd3,        4'd6},  // R6
    '{1'b1, ADR_INT_STAT, 32'h3,        4'd0, ADR_INT_STAT, 32'h0,        4'd8},  // R8
    '{1'b1, ADR_FREE_BUF, 32'd0,        4'd0, ADR_FREE_CUR, 32'd0,        4'd6},  // R6
    '{1'b0, ADR_CTRL,     32'h0,        4'd1, ADR_FREE_CUR, 32'hFFFF_FFFF, 4'd6}, // R6 wrap
    '{1'b0, ADR_CTRL,     32'h0,        4'd0, ADR_INT_STAT, 32'h0,        4'd6},  // R6
    '{1'b1, ADR_CTRL,     32'h0,        4'd3, ADR_FREE_CUR, 32'hFFFF_FFFF, 4'd2}  // R2
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              irq_o;
  int                n_run = 0;
  int                n_fail = 0;

  always #5 clk_i = ~clk_i;

  core_tick_timer u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(req, rdata_o, exp);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      if (TBL[v].wr) wr(TBL[v].waddr, TBL[v].wdata);
      ticks(int'(TBL[v].nt));
      rd($sformatf("R%0d vec%0d", TBL[v].req, v), TBL[v].raddr, TBL[v].exp);
    end

    // R8: pending interval status masked, then enabled
    wr(ADR_INT_EN, 32'h0);
    wr(ADR_IVL_BUF, 32'h8000_0000);
    wr(ADR_CTRL, 32'h3);
    ticks(1);
    rd("R4 stat", ADR_INT_STAT, 32'h1);
    chk("R8 masked", {31'b0, irq_o}, 32'h0);
    wr(ADR_INT_EN, 32'h1);
    #1 chk("R8 enable pending", {31'b0, irq_o}, 32'h1);
    wr(ADR_INT_STAT, 32'h1);
    #1 chk("R8 clear", {31'b0, irq_o}, 32'h0);

    // R6: free-running source drives irq through enable bit 1
    wr(ADR_CTRL, 32'h0);
    wr(ADR_FREE_BUF, 32'd1);
    wr(ADR_INT_EN, 32'h2);
    wr(ADR_CTRL, 32'h8);
    ticks(1);
    #1 chk("R6 irq", {31'b0, irq_o}, 32'h1);
    rd("R6 stat", ADR_INT_STAT, 32'h2);
    wr(ADR_INT_STAT, 32'h2);
    #1 chk("R8 clear free", {31'b0, irq_o}, 32'h0);

    // R9: observation registers ignore writes
    wr(ADR_IVL_CUR, 32'h7);
    rd("R9 ivl", ADR_IVL_CUR, 32'h0);
    wr(ADR_FREE_CUR, 32'h5);
    rd("R9 free", ADR_FREE_CUR, 32'h1);

    // R1: reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd("R1 ctrl", ADR_CTRL, 32'h0);
    rd("R1 free", ADR_FREE_CUR, 32'h0);
    rd("R1 wstat", ADR_WR_STAT, 32'h0);
    rd("R1 tickbuf", ADR_TICK_BUF, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule